// File: doc/BRIEF.md
# Saturating Result Writeback Stage

This block is the commit stage behind a fixed-point geometry datapath. Each command presents one wide signed result together with a target code. The stage clamps the result to the legal range of the chosen destination and writes it into one of several places: an accumulator bank, an intermediate bank, a depth-cue lane, an ordering-depth register, a three-entry screen-XY FIFO or a four-entry screen-Z FIFO. Every destination that can saturate has its own sticky flag bit. A summary error bit reports whether any flag is set.

A flag clear strobe marks the start of a new operation. When it arrives in the same cycle as a writeback, the flags are cleared first and the writeback's own flag effects are then applied. Software-style restoration of the flag word is done through a dedicated target code. All outputs are registered and take the new value one clock edge after the command.

Top module: `sat_writeback`

## Requirements
- R1: While rst is high at a clock edge, every output register becomes zero. This covers all accumulators, all intermediates, the ordering depth, all FIFO entries and all flags.
- R2: Target codes 0..3 write accumulator lanes 0..3 with the low 32 bits of cmd_val. A value above 2^31-1 sets the lane's overflow flag, and a value below -2^31 sets its underflow flag. Overflow flags are bit 16 for lane 0 and bits 30, 29, 28 for lanes 1, 2, 3. Underflow flags are bit 15 for lane 0 and bits 27, 26, 25 for lanes 1, 2, 3.
- R3: Target codes 5, 6, 7 write intermediate lanes 1, 2, 3, clamped to -32768..32767. A clamp sets flag bit 24, 23 or 22 respectively.
- R4: When cmd_lo_lim is high, the lower bound of intermediate lanes 1..3 becomes 0. A negative value then stores 0 and sets that lane's flag.
- R5: Target code 4 writes intermediate lane 0, the depth cue, clamped to 0..0x1000. A clamp sets flag bit 12.
- R6: Target code 8 writes the ordering depth, clamped to 0..0xFFFF. A clamp sets flag bit 18, and a screen-Z push shares this same flag bit.
- R7: Target code 10 pushes into the screen-Z FIFO. Entry k takes entry k+1, and entry 3 takes the value clamped as in R6.
- R8: Target code 9 takes X from cmd_val[31:0] and Y from cmd_val[63:32], both signed. Each is clamped to -1024..32767; an X clamp sets bit 14 and a Y clamp sets bit 13. The FIFO then shifts entry k to take entry k+1, and entry 2 takes {Y[15:0], X[15:0]}.
- R9: Target code 11 replaces flag bits 30:12 with cmd_val[30:12]. Flag bits 11:0 always read zero.
- R10: flag_clr zeroes flag bits 30:12 before the same cycle's writeback flag effects. Without flag_clr or a flag write, flags are sticky.
- R11: Flag bit 31 equals the OR of flag bits 30:12 after every update.
- R12: Target codes 12..15 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Writeback command strobe |
| cmd_sel | input | 4 | Target code |
| cmd_val | input | 64 | Signed result to commit |
| cmd_lo_lim | input | 1 | Lower-limit mode for intermediate lanes 1..3 |
| flag_clr | input | 1 | Clear flags at start of operation |
| acc_o | output | 128 | Accumulator lane k at [32k+31:32k] |
| ir_o | output | 64 | Intermediate lane k at [16k+15:16k], lane 0 is depth cue |
| otz_o | output | 16 | Ordering depth |
| sxy_o | output | 96 | Screen-XY entry k at [32k+31:32k], Y in upper half |
| sz_o | output | 64 | Screen-Z entry k at [16k+15:16k] |
| flag_o | output | 32 | Sticky flags with error summary in bit 31 |

## Verification
Every register is directly visible on a port. A wrong clamp bound, a swapped flag position or a misrouted FIFO shift therefore appears on the very next sample after the offending command. A flag that is wrongly set also lifts bit 31 in that same cycle. A stale or skipped FIFO entry is exposed within at most three further pushes, as it travels toward entry 0. Directed values sit exactly at and one past each bound in both directions, and random values span small, 32-bit and full 64-bit magnitudes.

// File: rtl/sat_wb_pkg.sv
package sat_wb_pkg;

  typedef logic [3:0] sel_t;

  localparam int ACC_N = 4;
  localparam int IR_N  = 4;
  localparam int FLAG_W = 32;

  localparam sel_t SEL_ACC0 = 4'd0;
  localparam sel_t SEL_IR0  = 4'd4;
  localparam sel_t SEL_OTZ  = 4'd8;
  localparam sel_t SEL_SXY  = 4'd9;
  localparam sel_t SEL_SZ   = 4'd10;
  localparam sel_t SEL_FLAG = 4'd11;

  localparam int FB_ERR  = 31;
  localparam int FB_LOW  = 12;
  localparam int FB_Z    = 18;
  localparam int FB_SX   = 14;
  localparam int FB_SY   = 13;
  localparam int FB_DQ   = 12;

  function automatic int acc_ovf_bit(input int lane);
    return (lane == 0) ? 16 : 31 - lane;
  endfunction

  function automatic int acc_unf_bit(input int lane);
    return (lane == 0) ? 15 : 28 - lane;
  endfunction

  function automatic int ir_sat_bit(input int lane);
    return (lane == 0) ? FB_DQ : 25 - lane;
  endfunction

endpackage

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0] val,
  input  logic signed [IN_W-1:0] lo,
  input  logic signed [IN_W-1:0] hi,
  output logic        [OUT_W-1:0] res,
  output logic                    hit
);
  logic signed [IN_W-1:0] clamped;
  logic                   unused_hi;

  always_comb begin
    hit     = 1'b0;
    clamped = val;
    if (val < lo) begin
      clamped = lo;
      hit     = 1'b1;
    end else if (val > hi) begin
      clamped = hi;
      hit     = 1'b1;
    end
  end

  assign res       = clamped[OUT_W-1:0];
  assign unused_hi = ^clamped[IN_W-1:OUT_W];
endmodule

// File: rtl/sat_shift_fifo.sv
module sat_shift_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] q
);
  logic [W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent[g] <= '0;
      end else if (push) begin
        if (g == DEPTH - 1) ent[g] <= din;
        else                ent[g] <= ent[g+1];
      end
    end
    assign q[g*W +: W] = ent[g];
  end
endmodule

// File: rtl/sat_writeback.sv
module sat_writeback
  import sat_wb_pkg::*;
#(
  parameter int VAL_W     = 64,
  parameter int ACC_W     = 32,
  parameter int IR_W      = 16,
  parameter int SZ_DEPTH  = 4,
  parameter int SXY_DEPTH = 3,
  parameter int DQ_MAX    = 4096,
  parameter int SXY_MIN   = -1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmd_valid,
  input  logic [3:0]                 cmd_sel,
  input  logic [VAL_W-1:0]           cmd_val,
  input  logic                       cmd_lo_lim,
  input  logic                       flag_clr,
  output logic [ACC_N*ACC_W-1:0]     acc_o,
  output logic [IR_N*IR_W-1:0]       ir_o,
  output logic [IR_W-1:0]            otz_o,
  output logic [SXY_DEPTH*2*IR_W-1:0] sxy_o,
  output logic [SZ_DEPTH*IR_W-1:0]   sz_o,
  output logic [FLAG_W-1:0]          flag_o
);
  localparam int HALF_W = VAL_W / 2;

  localparam logic signed [VAL_W-1:0] ACC_MAX =
    $signed({{(VAL_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
  localparam logic signed [VAL_W-1:0] ACC_MIN = ~ACC_MAX;
  localparam logic signed [VAL_W-1:0] IR_MAX =
    $signed({{(VAL_W-IR_W+1){1'b0}}, {(IR_W-1){1'b1}}});
  localparam logic signed [VAL_W-1:0] IR_MIN = ~IR_MAX;
  localparam logic signed [VAL_W-1:0] Z_MAX =
    $signed({{(VAL_W-IR_W){1'b0}}, {IR_W{1'b1}}});
  localparam logic signed [VAL_W-1:0] ZERO   = '0;
  localparam logic signed [VAL_W-1:0] DQ_HI  = VAL_W'(DQ_MAX);
  localparam logic signed [VAL_W-1:0] SXY_LO = VAL_W'(SXY_MIN);

  logic signed [VAL_W-1:0] val_s;
  logic                    wr;
  logic                    acc_hi, acc_lo;

  assign val_s  = $signed(cmd_val);
  assign wr     = cmd_valid;
  assign acc_hi = val_s > ACC_MAX;
  assign acc_lo = val_s < ACC_MIN;

  // accumulator bank: raw low bits, range only reported
  logic [ACC_W-1:0] acc_q [ACC_N];
  for (genvar g = 0; g < ACC_N; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)                                         acc_q[g] <= '0;
      else if (wr && cmd_sel == SEL_ACC0 + 4'(g))      acc_q[g] <= cmd_val[ACC_W-1:0];
    end
    assign acc_o[g*ACC_W +: ACC_W] = acc_q[g];
  end

  // intermediate bank: lane 0 is the depth cue, lanes 1.. signed
  logic [IR_W-1:0] ir_res [IR_N];
  logic [IR_N-1:0] ir_hit;
  logic [IR_W-1:0] ir_q   [IR_N];

  for (genvar g = 0; g < IR_N; g++) begin : g_ir
    logic signed [VAL_W-1:0] lo_b, hi_b;
    if (g == 0) begin : g_dq
      assign lo_b = ZERO;
      assign hi_b = DQ_HI;
    end else begin : g_lane
      assign lo_b = cmd_lo_lim ? ZERO : IR_MIN;
      assign hi_b = IR_MAX;
    end

    sat_clamp #(.IN_W(VAL_W), .OUT_W(IR_W)) clamp_u (
      .val(val_s), .lo(lo_b), .hi(hi_b), .res(ir_res[g]), .hit(ir_hit[g])
    );

    always_ff @(posedge clk) begin
      if (rst)                                     ir_q[g] <= '0;
      else if (wr && cmd_sel == SEL_IR0 + 4'(g))   ir_q[g] <= ir_res[g];
    end
    assign ir_o[g*IR_W +: IR_W] = ir_q[g];
  end

  // unsigned depth clamp shared by ordering depth and screen-Z push
  logic [IR_W-1:0] z_res;
  logic            z_hit;
  logic [IR_W-1:0] otz_q;

  sat_clamp #(.IN_W(VAL_W), .OUT_W(IR_W)) z_clamp_u (
    .val(val_s), .lo(ZERO), .hi(Z_MAX), .res(z_res), .hit(z_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)                            otz_q <= '0;
    else if (wr && cmd_sel == SEL_OTZ)  otz_q <= z_res;
  end
  assign otz_o = otz_q;

  sat_shift_fifo #(.DEPTH(SZ_DEPTH), .W(IR_W)) sz_fifo_u (
    .clk(clk), .rst(rst), .push(wr && cmd_sel == SEL_SZ), .din(z_res), .q(sz_o)
  );

  // screen XY: two signed halves, each clamped on its own
  logic signed [VAL_W-1:0] sx_s, sy_s;
  logic [IR_W-1:0]         sx_res, sy_res;
  logic                    sx_hit, sy_hit;

  assign sx_s = VAL_W'($signed(cmd_val[HALF_W-1:0]));
  assign sy_s = VAL_W'($signed(cmd_val[VAL_W-1:HALF_W]));

  sat_clamp #(.IN_W(VAL_W), .OUT_W(IR_W)) sx_clamp_u (
    .val(sx_s), .lo(SXY_LO), .hi(IR_MAX), .res(sx_res), .hit(sx_hit)
  );
  sat_clamp #(.IN_W(VAL_W), .OUT_W(IR_W)) sy_clamp_u (
    .val(sy_s), .lo(SXY_LO), .hi(IR_MAX), .res(sy_res), .hit(sy_hit)
  );

  sat_shift_fifo #(.DEPTH(SXY_DEPTH), .W(2*IR_W)) sxy_fifo_u (
    .clk(clk), .rst(rst), .push(wr && cmd_sel == SEL_SXY),
    .din({sy_res, sx_res}), .q(sxy_o)
  );

  // sticky flags: clear first, then this cycle's effects
  logic [FB_ERR-1:0] flg_q, flg_n;
  logic              err_q;

  always_comb begin
    flg_n = flag_clr ? '0 : flg_q;
    if (wr) begin
      for (int i = 0; i < ACC_N; i++) begin
        if (cmd_sel == SEL_ACC0 + 4'(i)) begin
          if (acc_hi) flg_n[acc_ovf_bit(i)] = 1'b1;
          if (acc_lo) flg_n[acc_unf_bit(i)] = 1'b1;
        end
      end
      for (int i = 0; i < IR_N; i++) begin
        if (cmd_sel == SEL_IR0 + 4'(i) && ir_hit[i]) flg_n[ir_sat_bit(i)] = 1'b1;
      end
      if ((cmd_sel == SEL_OTZ || cmd_sel == SEL_SZ) && z_hit) flg_n[FB_Z] = 1'b1;
      if (cmd_sel == SEL_SXY) begin
        if (sx_hit) flg_n[FB_SX] = 1'b1;
        if (sy_hit) flg_n[FB_SY] = 1'b1;
      end
      if (cmd_sel == SEL_FLAG) begin
        flg_n = '0;
        flg_n[FB_ERR-1:FB_LOW] = cmd_val[FB_ERR-1:FB_LOW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
      err_q <= 1'b0;
    end else begin
      flg_q <= flg_n;
      err_q <= |flg_n[FB_ERR-1:FB_LOW];
    end
  end

  assign flag_o = {err_q, flg_q};
endmodule

// File: rtl/sat_writeback_chk.sv
module sat_writeback_chk
  import sat_wb_pkg::*;
#(
  parameter int VAL_W     = 64,
  parameter int ACC_W     = 32,
  parameter int IR_W      = 16,
  parameter int SZ_DEPTH  = 4,
  parameter int SXY_DEPTH = 3,
  parameter int DQ_MAX    = 4096
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cmd_valid,
  input logic [3:0]                  cmd_sel,
  input logic [VAL_W-1:0]            cmd_val,
  input logic                        cmd_lo_lim,
  input logic                        flag_clr,
  input logic [ACC_N*ACC_W-1:0]      acc_o,
  input logic [IR_N*IR_W-1:0]        ir_o,
  input logic [IR_W-1:0]             otz_o,
  input logic [SXY_DEPTH*2*IR_W-1:0] sxy_o,
  input logic [SZ_DEPTH*IR_W-1:0]    sz_o,
  input logic [FLAG_W-1:0]           flag_o
);
  localparam int XW = 2 * IR_W;

  p_sz_shift_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_sel == SEL_SZ |=>
      sz_o[(SZ_DEPTH-1)*IR_W-1:0] == $past(sz_o[SZ_DEPTH*IR_W-1:IR_W]));

  p_sxy_shift_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_sel == SEL_SXY |=>
      sxy_o[(SXY_DEPTH-1)*XW-1:0] == $past(sxy_o[SXY_DEPTH*XW-1:XW]));

  p_flag_low_zero_r9: assert property (@(posedge clk) disable iff (rst)
    flag_o[FB_LOW-1:0] == '0);

  p_err_summary_r11: assert property (@(posedge clk) disable iff (rst)
    flag_o[FB_ERR] == |flag_o[FB_ERR-1:FB_LOW]);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !cmd_valid |=> flag_o == '0);

  p_depth_max_r5: assert property (@(posedge clk) disable iff (rst)
    ir_o[IR_W-1:0] <= IR_W'(DQ_MAX));

  p_lolim_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_sel == SEL_IR0 + 4'd1 && cmd_lo_lim |=> !ir_o[2*IR_W-1]);

  p_unused_sel_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_sel > SEL_FLAG && !flag_clr |=>
      $stable(acc_o) && $stable(ir_o) && $stable(otz_o) &&
      $stable(sxy_o) && $stable(sz_o) && $stable(flag_o));

  logic unused_in;
  assign unused_in = ^cmd_val;
endmodule

bind sat_writeback sat_writeback_chk #(
  .VAL_W(VAL_W), .ACC_W(ACC_W), .IR_W(IR_W),
  .SZ_DEPTH(SZ_DEPTH), .SXY_DEPTH(SXY_DEPTH), .DQ_MAX(DQ_MAX)
) chk_i (.*);

// File: tb/sat_writeback_tb_top.sv
module sat_writeback_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [3:0]   cmd_sel = '0;
  logic [63:0]  cmd_val = '0;
  logic         cmd_lo_lim = 1'b0;
  logic         flag_clr = 1'b0;
  logic [127:0] acc_o;
  logic [63:0]  ir_o;
  logic [15:0]  otz_o;
  logic [95:0]  sxy_o;
  logic [63:0]  sz_o;
  logic [31:0]  flag_o;

  always #10 clk = ~clk;

  sat_writeback dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_val(cmd_val), .cmd_lo_lim(cmd_lo_lim), .flag_clr(flag_clr),
    .acc_o(acc_o), .ir_o(ir_o), .otz_o(otz_o), .sxy_o(sxy_o),
    .sz_o(sz_o), .flag_o(flag_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic [31:0] m_acc [4];
  logic [15:0] m_ir  [4];
  logic [15:0] m_otz;
  logic [31:0] m_sxy [3];
  logic [15:0] m_sz  [4];
  logic [30:0] m_flg;
  bit          m_err;
  bit          m_hit;

  function automatic longint clmp(longint x, longint lo, longint hi);
    m_hit = 1'b0;
    if (x < lo) begin m_hit = 1'b1; return lo; end
    if (x > hi) begin m_hit = 1'b1; return hi; end
    return x;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_acc[i] = '0; m_ir[i] = '0; m_sz[i] = '0; end
    for (int i = 0; i < 3; i++) m_sxy[i] = '0;
    m_otz = '0; m_flg = '0; m_err = 1'b0;
  endtask

  task automatic model_apply(logic [3:0] sel, logic [63:0] v, bit lm, bit clr);
    longint sv, r, x, y;
    bit hx, hy;
    sv = $signed(v);
    if (clr) m_flg = '0;
    if (sel <= 4'd3) begin                       // R2
      m_acc[sel] = v[31:0];
      if (sv > 64'sd2147483647)  m_flg[(sel == 0) ? 16 : 31 - sel] = 1'b1;
      else if (sv < -64'sd2147483648) m_flg[(sel == 0) ? 15 : 28 - sel] = 1'b1;
    end else if (sel == 4'd4) begin              // R5
      r = clmp(sv, 0, 4096); m_ir[0] = r[15:0];
      if (m_hit) m_flg[12] = 1'b1;
    end else if (sel <= 4'd7) begin              // R3, R4
      r = clmp(sv, lm ? 0 : -32768, 32767); m_ir[sel-4] = r[15:0];
      if (m_hit) m_flg[25 - (sel - 4)] = 1'b1;
    end else if (sel == 4'd8) begin              // R6
      r = clmp(sv, 0, 65535); m_otz = r[15:0];
      if (m_hit) m_flg[18] = 1'b1;
    end else if (sel == 4'd9) begin              // R8
      x = clmp(longint'($signed(v[31:0])), -1024, 32767); hx = m_hit;
      y = clmp(longint'($signed(v[63:32])), -1024, 32767); hy = m_hit;
      m_sxy[0] = m_sxy[1]; m_sxy[1] = m_sxy[2]; m_sxy[2] = {y[15:0], x[15:0]};
      if (hx) m_flg[14] = 1'b1;
      if (hy) m_flg[13] = 1'b1;
    end else if (sel == 4'd10) begin             // R7
      r = clmp(sv, 0, 65535);
      m_sz[0] = m_sz[1]; m_sz[1] = m_sz[2]; m_sz[2] = m_sz[3]; m_sz[3] = r[15:0];
      if (m_hit) m_flg[18] = 1'b1;
    end else if (sel == 4'd11) begin             // R9
      m_flg = v[30:0] & 31'h7FFF_F000;
    end
    m_err = |m_flg[30:12];                       // R11
  endtask

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " acc"},  128'(acc_o), {m_acc[3], m_acc[2], m_acc[1], m_acc[0]});
    chk({tag, " ir"},   128'(ir_o),  128'({m_ir[3], m_ir[2], m_ir[1], m_ir[0]}));
    chk({tag, " otz"},  128'(otz_o), 128'(m_otz));
    chk({tag, " sxy"},  128'(sxy_o), 128'({m_sxy[2], m_sxy[1], m_sxy[0]}));
    chk({tag, " sz"},   128'(sz_o),  128'({m_sz[3], m_sz[2], m_sz[1], m_sz[0]}));
    chk({tag, " flag R11"}, 128'(flag_o), 128'({m_err, m_flg}));
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic op(logic [3:0] sel, logic [63:0] v, bit lm, bit clr, string tag);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_val = v; cmd_lo_lim = lm; flag_clr = clr;
    model_apply(sel, v, lm, clr);
    @(negedge clk);
    cmd_valid = 1'b0; flag_clr = 1'b0;
    compare_all(tag);
  endtask

  task automatic clear_only(string tag);
    flag_clr = 1'b1;
    m_flg = '0; m_err = 1'b0;
    @(negedge clk);
    flag_clr = 1'b0;
    compare_all(tag);
  endtask

  function automatic logic [31:0] rnd32();
    case ($urandom % 5)
      0: return 32'($signed(16'($urandom)));
      1: return 32'($signed(($urandom % 7000)) - 2000);
      2: return $urandom;
      3: return 32'(32767 + ($urandom % 3)) ^ (($urandom % 2) != 0 ? 32'hFFFF_FFFF : 32'h0);
      default: return 32'(-1026 + int'($urandom % 5));
    endcase
  endfunction

  function automatic logic [63:0] rnd64();
    case ($urandom % 4)
      0: return 64'($signed(rnd32()));
      1: return {$urandom, $urandom};
      2: return 64'sd2147483646 + 64'($urandom % 4) -
                (($urandom % 2) != 0 ? 64'sd4294967295 + 64'sd2 : 64'sd0);
      default: return {rnd32(), rnd32()};
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] s, bit lm);
    if (s <= 3)  return "R2";
    if (s == 4)  return "R5";
    if (s <= 7)  return lm ? "R4" : "R3";
    if (s == 8)  return "R6";
    if (s == 9)  return "R8";
    if (s == 10) return "R7";
    if (s == 11) return "R9";
    return "R12";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7719));
    model_reset();
    cmd_val = 64'hDEAD_BEEF_1234_5678;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst = 1'b0;

    // accumulator boundaries
    op(4'd1, 64'sd2147483647,  0, 1, "R2 max");
    op(4'd1, 64'sd2147483648,  0, 0, "R2 ovf");
    op(4'd2, -64'sd2147483648, 0, 1, "R2 min");
    op(4'd3, -64'sd2147483649, 0, 0, "R2 unf");
    op(4'd0, 64'h0000_0010_0000_0005, 0, 0, "R2 lane0 ovf");
    op(4'd0, 64'hFFFF_FFEF_0000_0005, 0, 1, "R2 lane0 unf");
    // intermediates
    op(4'd5, 64'sd32767,  0, 1, "R3 max");
    op(4'd5, 64'sd32768,  0, 0, "R3 over");
    op(4'd6, -64'sd32768, 0, 1, "R3 min");
    op(4'd7, -64'sd32769, 0, 0, "R3 under");
    op(4'd5, -64'sd1,     1, 1, "R4 neg");
    op(4'd6, 64'sd0,      1, 1, "R4 zero");
    op(4'd7, 64'sd40000,  1, 0, "R4 over");
    // depth cue
    op(4'd4, 64'sd4096, 0, 1, "R5 max");
    op(4'd4, 64'sd4097, 0, 0, "R5 over");
    op(4'd4, -64'sd1,   0, 1, "R5 neg");
    // ordering depth and screen Z
    op(4'd8, 64'sd65535, 0, 1, "R6 max");
    op(4'd8, 64'sd65536, 0, 0, "R6 over");
    op(4'd8, -64'sd5,    0, 1, "R6 neg");
    for (int i = 0; i < 5; i++) op(4'd10, 64'(100 * i + 7), 0, 1, "R7 fill");
    op(4'd10, 64'sd70000, 0, 1, "R7 sat");
    // screen XY
    op(4'd9, {32'sd5, -32'sd1025}, 0, 1, "R8 x low");
    op(4'd9, {32'sd32768, 32'sd3}, 0, 1, "R8 y high");
    op(4'd9, {-32'sd1024, 32'sd32767}, 0, 1, "R8 edges");
    op(4'd9, {-32'sd2000, 32'sd40000}, 0, 0, "R8 both");
    // flag word
    op(4'd11, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R9 all ones");
    clear_only("R10 clear");
    op(4'd11, 64'h0000_0000_0000_1000, 0, 0, "R9 single");
    op(4'd5, 64'sd1, 0, 1, "R10 clear then write");
    op(4'd5, 64'sd99999, 0, 0, "R10 sticky a");
    op(4'd6, 64'sd1, 0, 0, "R10 sticky b");
    // unused codes
    for (int s = 12; s < 16; s++) op(4'(s), {$urandom, $urandom}, 0, 0, "R12 ignored");

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] s;
      bit lm;
      s  = 4'($urandom % 16);
      lm = ($urandom % 3) == 0;
      op(s, rnd64(), lm, ($urandom % 6) == 0, tag_of(s, lm));
    end

    finish_run();
  end
endmodule